// File: doc/BRIEF.md
# Byte-Packing Clock-Crossing Word Buffer

This block carries a byte stream from a slow write clock to a much faster read clock. In the write domain, bytes are paired into 16-bit words and written into a small dual-port memory at an address that steps by one per word. The read domain never receives the full write pointer. Only bit 0 of the write address crosses, through a two-flop synchronizer. Each rising or falling change of that bit moves a local tracking address forward by one. The reader fetches a word whenever its own address trails the tracking address.

Both clocks are fixed and free-running. The read clock must run at least three read cycles per stored word. This makes every change of the crossed bit visible before the next one.

One asynchronous reset clears both domains. The write side stays closed until the read side confirms that its addresses and its synchronizer have been cleared. This guarantees that both sides restart from address zero.

The writer is a three-state machine:
- WS_HOLD waits for the read-side clear acknowledge.
- WS_LOW waits for the first byte of a pair.
- WS_HIGH waits for the second byte.

Its transitions are:
- HOLD→LOW on the acknowledge.
- LOW→HIGH on an accepted first byte.
- HIGH→LOW on an accepted second byte, which also writes memory.
- Any state→HOLD on reset.

The reader is also a three-state machine:
- RS_CLEAR is the single cycle after reset, in which the clear is acknowledged.
- RS_IDLE means no word is presented.
- RS_DRAIN means a word is presented.

Its transitions are:
- CLEAR→IDLE unconditionally.
- IDLE or DRAIN→DRAIN when the read address differs from the tracking address.
- IDLE or DRAIN→IDLE otherwise.

Top module: `xclk_word_buffer`

## Requirements
- R1: After `rst_n` is released, `wr_ready` stays 0 until the read domain has cleared. It then rises within 8 write-clock cycles of the release.
- R2: A byte offered with `wr_valid`=1 while `wr_ready`=0 is discarded. It forms no word and does not take part in any pairing.
- R3: Within a word, the first accepted byte of a pair appears on `rd_word[7:0]` and the second appears on `rd_word[15:8]`.
- R4: Every stored word is delivered exactly once and in write order. `rd_valid` is high for one read cycle per word.
- R5: A lone first byte produces no output until its partner byte has been accepted.
- R6: A word appears on `rd_valid` no later than 8 read-clock periods after the write-clock edge that accepted its second byte.
- R7: The memory holds 16 words with 4-bit wrapping addresses. A stream longer than 16 words passes through intact, provided the writer is never more than 15 words ahead of the reader.
- R8: The reader presents a word only when its read address trailed the tracking address in the previous read cycle. The read address moves only by +1, and only together with a presented word.
- R9: While `rst_n` is low, `rd_valid` and `wr_ready` are 0. A reset during operation discards any half-built pair and any unread words. After release, pairing restarts with a new first byte.
- R10: Transitions of the synchronized address bit never occur on two consecutive read cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Slow write-domain clock |
| rd_clk | input | 1 | Fast read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_valid | input | 1 | A byte is offered on wr_byte |
| wr_byte | input | 8 | Input byte |
| wr_ready | output | 1 | The write side accepts bytes |
| rd_valid | output | 1 | rd_word carries a word this read cycle |
| rd_word | output | 16 | Output word |

## Verification
The case hardest to reach from the ports is a reset that lands in the middle of operation. It must leave one byte of a pair stranded and also open the hold window, during which offered bytes must vanish. The stimulus first drains the buffer and offers a single byte. It then pulses `rst_n` and keeps offering bytes on every write cycle until `wr_ready` returns. The behavioural queue model must then show that the first word after the reset is built only from bytes accepted after `wr_ready` rose. Long back-to-back streams of more than 16 words exercise address wrap. Streams with random gaps vary the spacing of the crossed bit's transitions.

// File: rtl/xwb_pkg.sv
`timescale 1ns/1ps
package xwb_pkg;
    typedef enum logic [1:0] {
        WS_HOLD = 2'd0,
        WS_LOW  = 2'd1,
        WS_HIGH = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        RS_CLEAR = 2'd0,
        RS_IDLE  = 2'd1,
        RS_DRAIN = 2'd2
    } rd_state_e;
endpackage

// File: rtl/xwb_bit_sync.sv
`timescale 1ns/1ps
// Multi-stage flop chain into the clk domain, async-cleared to 0.
// With d tied high it serves as a reset synchronizer.
module xwb_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stage_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= 1'b0;
                else        stage_q[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= 1'b0;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/xwb_dpram.sv
`timescale 1ns/1ps
// Simple dual-port memory: one write port, one registered read port.
module xwb_dpram #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_clk,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rd_clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/xwb_toggle_track.sv
`timescale 1ns/1ps
// Turns transitions of a synchronized level into steps of a trailing address.
module xwb_toggle_track #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl,
    output logic              toggle,
    output logic [ADDR_W-1:0] track
);
    logic prev_q;

    assign toggle = lvl ^ prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            track  <= '0;
        end else begin
            prev_q <= lvl;
            track  <= track + {{(ADDR_W-1){1'b0}}, toggle};
        end
    end
endmodule

// File: rtl/xwb_pack_fsm.sv
`timescale 1ns/1ps
// Write side: waits for the read-side clear, then pairs bytes into words.
module xwb_pack_fsm
    import xwb_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_ok,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_byte,
    output logic                ready,
    output logic                we,
    output logic [ADDR_W-1:0]   waddr,
    output logic [2*BYTE_W-1:0] wdata
);
    wr_state_e         state_q, state_d;
    logic [BYTE_W-1:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_HOLD: if (clear_ok) state_d = WS_LOW;
            WS_LOW:  if (in_valid) state_d = WS_HIGH;
            WS_HIGH: if (in_valid) state_d = WS_LOW;
            default: state_d = WS_HOLD;
        endcase
    end

    always_comb begin
        ready = (state_q != WS_HOLD);
        we    = (state_q == WS_HIGH) && in_valid;
        wdata = {in_byte, lo_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q  <= '0;
            waddr <= '0;
        end else begin
            if (state_q == WS_LOW && in_valid) lo_q <= in_byte;
            if (we) waddr <= waddr + 1'b1;
        end
    end
endmodule

// File: rtl/xwb_drain_fsm.sv
`timescale 1ns/1ps
// Read side: acknowledges the clear, then reads while behind the tracking address.
module xwb_drain_fsm
    import xwb_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] track,
    output logic              re,
    output logic [ADDR_W-1:0] raddr,
    output logic              cleared,
    output logic              out_valid
);
    rd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        re      = (state_q != RS_CLEAR) && (raddr != track);
        state_d = state_q;
        unique case (state_q)
            RS_CLEAR: state_d = RS_IDLE;
            RS_IDLE:  state_d = re ? RS_DRAIN : RS_IDLE;
            RS_DRAIN: state_d = re ? RS_DRAIN : RS_IDLE;
            default:  state_d = RS_CLEAR;
        endcase
    end

    always_comb begin
        out_valid = (state_q == RS_DRAIN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raddr   <= '0;
            cleared <= 1'b0;
        end else begin
            cleared <= (state_d != RS_CLEAR);
            if (re) raddr <= raddr + 1'b1;
        end
    end
endmodule

// File: rtl/xclk_word_buffer.sv
`timescale 1ns/1ps
module xclk_word_buffer #(
    parameter int BYTE_W      = 8,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                wr_clk,
    input  logic                rd_clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [BYTE_W-1:0]   wr_byte,
    output logic                wr_ready,
    output logic                rd_valid,
    output logic [2*BYTE_W-1:0] rd_word
);
    localparam int WORD_W = 2 * BYTE_W;

    logic              wr_rst_n_s, rd_rst_n_s;
    logic              rd_cleared, ack_w;
    logic              we, re, lsb_r, toggle;
    logic [ADDR_W-1:0] waddr, raddr, track;
    logic [WORD_W-1:0] wdata;

    xwb_bit_sync #(.STAGES(SYNC_STAGES)) i_wr_rst (
        .clk(wr_clk), .rst_n(rst_n), .d(1'b1), .q(wr_rst_n_s));

    xwb_bit_sync #(.STAGES(SYNC_STAGES)) i_rd_rst (
        .clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(rd_rst_n_s));

    xwb_bit_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
        .clk(wr_clk), .rst_n(wr_rst_n_s), .d(rd_cleared), .q(ack_w));

    xwb_bit_sync #(.STAGES(SYNC_STAGES)) i_lsb_sync (
        .clk(rd_clk), .rst_n(rd_rst_n_s), .d(waddr[0]), .q(lsb_r));

    xwb_pack_fsm #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) i_pack (
        .clk(wr_clk), .rst_n(wr_rst_n_s), .clear_ok(ack_w),
        .in_valid(wr_valid), .in_byte(wr_byte), .ready(wr_ready),
        .we(we), .waddr(waddr), .wdata(wdata));

    xwb_toggle_track #(.ADDR_W(ADDR_W)) i_track (
        .clk(rd_clk), .rst_n(rd_rst_n_s), .lvl(lsb_r),
        .toggle(toggle), .track(track));

    xwb_drain_fsm #(.ADDR_W(ADDR_W)) i_drain (
        .clk(rd_clk), .rst_n(rd_rst_n_s), .track(track), .re(re),
        .raddr(raddr), .cleared(rd_cleared), .out_valid(rd_valid));

    xwb_dpram #(.DATA_W(WORD_W), .ADDR_W(ADDR_W)) i_ram (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wdata),
        .rd_clk(rd_clk), .re(re), .raddr(raddr), .rdata(rd_word));
endmodule

// File: rtl/xwb_checker.sv
`timescale 1ns/1ps
module xwb_checker #(
    parameter int ADDR_W = 4
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              wr_rst_n_s,
    input logic              rd_rst_n_s,
    input logic              ack_w,
    input logic              wr_ready,
    input logic              we,
    input logic [ADDR_W-1:0] waddr,
    input logic [ADDR_W-1:0] raddr,
    input logic [ADDR_W-1:0] track,
    input logic              toggle,
    input logic              rd_valid
);
    logic [ADDR_W-1:0] occ;
    always_comb occ = waddr - raddr;

    // R1: no byte is accepted before the read side has acknowledged its clear
    p_hold_until_clear_r1: assert property (@(posedge wr_clk) disable iff (!wr_rst_n_s)
        !ack_w |-> !wr_ready);

    // R7: the writer never gets a full memory ahead of the reader
    p_no_overflow_r7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n_s)
        we |-> (occ != {ADDR_W{1'b1}}));

    // R8: a presented word implies the read address was behind the tracking address
    p_read_lags_r8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n_s)
        rd_valid |-> ($past(raddr) != $past(track)));

    // R8: the read address steps by one, only together with a presented word
    p_raddr_step_r8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n_s)
        (raddr != $past(raddr)) |-> (rd_valid && raddr == $past(raddr) + 1'b1));

    // R10: synchronized transitions are spaced apart
    p_toggle_spacing_r10: assert property (@(posedge rd_clk) disable iff (!rd_rst_n_s)
        toggle |=> !toggle);

    // R9: no output word while the read domain is held in reset
    p_quiet_in_reset_r9: assert property (@(posedge rd_clk)
        !rd_rst_n_s |-> !rd_valid);
endmodule

bind xclk_word_buffer xwb_checker #(.ADDR_W(ADDR_W)) i_xwb_checker (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n_s(wr_rst_n_s),
    .rd_rst_n_s(rd_rst_n_s), .ack_w(ack_w), .wr_ready(wr_ready),
    .we(we), .waddr(waddr), .raddr(raddr), .track(track),
    .toggle(toggle), .rd_valid(rd_valid));

// File: tb/test_xclk_word_buffer.sv
`timescale 1ns/1ps
module test_xclk_word_buffer;
    localparam int RD_PERIOD = 4;
    localparam int WR_PERIOD = 20;

    logic        wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b1;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_byte = '0;
    logic        wr_ready, rd_valid;
    logic [15:0] rd_word;

    int checks = 0, failures = 0, rd_seen = 0;
    logic [15:0] exp_q[$];
    time         t_q[$];
    bit          half = 0;
    logic [7:0]  lo_byte = '0;
    logic [15:0] w_exp;
    time         t_exp;
    bit          done = 0;

    xclk_word_buffer i_xclk_word_buffer (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_byte(wr_byte), .wr_ready(wr_ready),
        .rd_valid(rd_valid), .rd_word(rd_word));

    always #(WR_PERIOD/2) wr_clk = ~wr_clk;
    initial begin
        #1;
        forever #(RD_PERIOD/2) rd_clk = ~rd_clk;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model: compares every presented word on each read clock
    always @(negedge rd_clk) begin
        if (rst_n && rd_valid) begin
            rd_seen++;
            if (exp_q.size() == 0) begin
                chk(0, "R4", "word without a stored word", rd_word, 0);
            end else begin
                w_exp = exp_q.pop_front();
                t_exp = t_q.pop_front();
                chk(rd_word == w_exp, "R3", "word content", rd_word, w_exp);
                chk(($time - t_exp) <= 8*RD_PERIOD, "R6", "latency ns",
                    int'($time - t_exp), 8*RD_PERIOD);
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        bit acc;
        @(negedge wr_clk);
        wr_valid = 1'b1;
        wr_byte  = b;
        acc      = wr_ready;
        @(posedge wr_clk);
        if (acc) begin
            if (!half) begin
                lo_byte = b;
                half    = 1;
            end else begin
                exp_q.push_back({b, lo_byte});
                t_q.push_back($time);
                half = 0;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_valid = 1'b0;
        end
    endtask

    // Reset pulse, then offer bytes during the hold window (all must be dropped)
    task automatic do_reset();
        int n;
        int seen0;
        @(negedge wr_clk);
        rst_n    = 1'b0;
        wr_valid = 1'b0;
        exp_q.delete();
        t_q.delete();
        half = 0;
        repeat (3) @(negedge wr_clk);
        chk(!rd_valid, "R9", "rd_valid in reset", rd_valid, 0);
        chk(!wr_ready, "R9", "wr_ready in reset", wr_ready, 0);
        rst_n = 1'b1;
        seen0 = rd_seen;
        chk(!wr_ready, "R1", "wr_ready right after release", wr_ready, 0);
        n = 0;
        while (!wr_ready && n < 20) begin
            wr_valid = 1'b1;
            wr_byte  = 8'hE0 + 8'(n);
            @(negedge wr_clk);
            n++;
        end
        wr_valid = 1'b0;
        chk(n <= 8, "R1", "write cycles until ready", n, 8);
        idle(6);
        chk(rd_seen == seen0, "R2", "words from bytes offered while not ready",
            rd_seen - seen0, 0);
    endtask

    task automatic wait_drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 200) begin
            @(negedge rd_clk);
            n++;
        end
        repeat (10) @(negedge rd_clk);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        repeat (2) @(negedge wr_clk);
        chk(!wr_ready, "R9", "reset state wr_ready", wr_ready, 0);
        chk(!rd_valid, "R9", "reset state rd_valid", rd_valid, 0);
        do_reset();

        // R5: a lone first byte yields nothing until its partner arrives
        begin
            int s0;
            s0 = rd_seen;
            send_byte(8'h5A);
            idle(12);
            chk(rd_seen == s0, "R5", "words after lone byte", rd_seen - s0, 0);
            send_byte(8'hC3);
            idle(4);
            chk(rd_seen == s0 + 1, "R5", "words after partner", rd_seen - s0, 1);
        end

        // R7: 40 back-to-back words wrap the 16-entry memory
        for (int k = 0; k < 80; k++) send_byte(8'(k * 7 + 1));
        idle(1);
        wait_drain();
        chk(exp_q.size() == 0, "R7", "words left after wrap stream", exp_q.size(), 0);

        // R4: gapped stream with varying spacing
        for (int k = 0; k < 40; k++) begin
            send_byte(8'(8'hA0 ^ k));
            if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
        end
        idle(1);
        wait_drain();
        chk(exp_q.size() == 0, "R4", "words left after gapped stream", exp_q.size(), 0);

        // R9: reset with a half-built pair pending, then pairing restarts
        send_byte(8'h77);
        idle(1);
        do_reset();
        send_byte(8'h11);
        send_byte(8'h22);
        send_byte(8'h33);
        send_byte(8'h44);
        idle(1);
        wait_drain();
        chk(exp_q.size() == 0, "R9", "words left after restart", exp_q.size(), 0);
        chk(half == 0, "R4", "model pair state at end", half, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(100000 * RD_PERIOD);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R4 watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule